// File: doc/BRIEF.md
# Parallel LZ77 Substring Hash Stage

This block is the entry stage of a compressor that consumes a window of VEC bytes in every clock cycle. It keeps one window back, so that when the window after it arrives both are visible together. For each of the VEC byte offsets of the held window, it builds a substring of VEC bytes that starts at that offset. Substrings that begin late in the held window take their remaining bytes from the window that follows. Each substring gets a hash index into the dictionary memory used by the later matching stages. Each lane also carries the absolute stream position of its first byte and a flag that tells whether the whole substring lies inside real data.

Windows enter and leave through valid/ready handshakes. A held window is released only when its successor is accepted, or when it was marked as the last window of a stream. In the last case the missing bytes are taken as zero and the lanes that reach past the data are flagged. The position counter then restarts for the next stream.

Top module: `lz_hash_stage`

## Requirements
- R1: After reset, outValid is 0 and inReady is 1.
- R2: Window byte k sits at inData[8k+7:8k] and comes first in the stream. Byte j of lane i (outSub bits [(i*VEC+j)*8 +: 8]) equals stream byte i+j counted from the held window's first byte, so it reaches into the next window when i+j >= VEC. For VEC=4, held ABAA and next ABCD, lanes 0 to 3 hold ABAA, BAAA, AAAB and AABC.
- R3: The lane hash (outHash bits [i*HASH_W +: HASH_W]) is formed as follows. Let X (2*HASH_W bits) be the XOR over j of (substring byte j times 157, as a 16-bit product) shifted left by j mod 8. The hash is X[HASH_W-1:0] XOR X[2*HASH_W-1:HASH_W].
- R4: Lane i position (outPos bits [i*POS_W +: POS_W]) equals the held window's base plus i. The first window after reset has base 0, each later window adds VEC, and the window after a last window starts again at 0.
- R5: A window accepted while no window is held produces no output until its successor is accepted.
- R6: When the held window is marked last (inLast at its acceptance), it is emitted with zero bytes in place of the next window. outFull[0] is then 1 and all other outFull bits are 0. For every other window, all outFull bits are 1.
- R7: While outValid is 1 and outReady is 0, outValid and every output field hold their values.
- R8: Every accepted window is emitted exactly once and in order, whatever the pattern of stalls on outReady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input window offered |
| inReady | output | 1 | Input window accepted this cycle when inValid is also high |
| inData | input | VEC*8 | Input window, byte 0 in the low bits |
| inLast | input | 1 | Offered window is the final one of its stream |
| outValid | output | 1 | Output lanes hold a result |
| outReady | input | 1 | Downstream takes the result |
| outSub | output | VEC*VEC*8 | Substring of each lane |
| outHash | output | VEC*HASH_W | Hash index of each lane |
| outPos | output | VEC*POS_W | Absolute position of each lane's first byte |
| outFull | output | VEC | Lane substring lies fully inside real data |

## Verification
The bench builds the block with VEC=4 and HASH_W=12. At that size the four-byte ABAA/ABCD example can be checked directly. Every lane from 1 to 3 borrows one to three bytes from the next window, so the boundary crossing is covered at every depth. With VEC=4, only hash shifts 0 to 3 are exercised. A repeating stall pattern on outReady meets both normal hand-overs and last-window flushes, and the bench also runs a single-window stream that is flushed with no successor.

// File: rtl/lzh_pkg.sv
package lzh_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic takeIn;   // capture the offered window into the hold register
    logic loadOut;  // load the output lanes from held + next window
    logic padNext;  // next window is replaced by zeros (flush of a last window)
  } lzhStrobe_t;
endpackage

// File: rtl/lzh_ctrl.sv
module lzh_ctrl
  import lzh_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inLast,
  output logic       inReady,
  output logic       outValid,
  input  logic       outReady,
  output lzhStrobe_t strobe
);
  logic heldValid;
  logic heldLast;
  logic canLoad;
  logic draining;

  assign canLoad  = !outValid || outReady;
  assign draining = heldValid && heldLast;
  assign inReady  = canLoad && !draining;

  always_comb begin
    strobe.takeIn  = inValid && inReady;
    strobe.padNext = draining;
    strobe.loadOut = draining ? canLoad : (inValid && inReady && heldValid);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldValid <= 1'b0;
      heldLast  <= 1'b0;
      outValid  <= 1'b0;
    end else begin
      if (strobe.takeIn) begin
        heldValid <= 1'b1;
        heldLast  <= inLast;
      end else if (draining && canLoad) begin
        heldValid <= 1'b0;
        heldLast  <= 1'b0;
      end
      if (strobe.loadOut)  outValid <= 1'b1;
      else if (outReady)   outValid <= 1'b0;
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid);

  // R5
  first_window_hidden_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && !heldValid && !outValid |=> !outValid);

  // R8
  drain_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    heldValid && heldLast && outValid && !outReady |=> heldValid && heldLast);
endmodule

// File: rtl/lzh_datapath.sv
module lzh_datapath
  import lzh_pkg::*;
#(
  parameter int VEC    = 16,
  parameter int HASH_W = 12,
  parameter int POS_W  = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  lzhStrobe_t                strobe,
  input  logic [VEC*8-1:0]          inData,
  input  logic                      inLast,
  input  logic                      outValidQ,
  input  logic                      outReady,
  output logic [VEC*VEC*8-1:0]      outSub,
  output logic [VEC*HASH_W-1:0]     outHash,
  output logic [VEC*POS_W-1:0]      outPos,
  output logic [VEC-1:0]            outFull
);
  localparam int WB = VEC * 8;
  localparam int XW = 2 * HASH_W;

  logic [WB-1:0]          heldData;
  logic [POS_W-1:0]       heldBase;
  logic [POS_W-1:0]       nextBase;
  logic [2*WB-1:0]        cat;
  logic [VEC*WB-1:0]      subC;
  logic [VEC*HASH_W-1:0]  hashC;
  logic [VEC*POS_W-1:0]   posC;
  logic [VEC-1:0]         fullC;

  function automatic logic [HASH_W-1:0] hashSub(input logic [WB-1:0] s);
    logic [XW-1:0] x;
    logic [15:0]   p;
    x = '0;
    for (int j = 0; j < VEC; j++) begin
      p = 16'(s[8*j +: 8]) * 16'd157;
      x = x ^ (XW'(p) << (j % 8));
    end
    return x[HASH_W-1:0] ^ x[XW-1:HASH_W];
  endfunction

  assign cat = {(strobe.padNext ? {WB{1'b0}} : inData), heldData};

  for (genvar i = 0; i < VEC; i++) begin : g_lane
    for (genvar j = 0; j < VEC; j++) begin : g_byte
      assign subC[(i*VEC+j)*8 +: 8] = cat[(i+j)*8 +: 8];
    end
    assign hashC[i*HASH_W +: HASH_W] = hashSub(subC[i*WB +: WB]);
    assign posC[i*POS_W +: POS_W]    = heldBase + POS_W'(i);
    assign fullC[i]                  = !strobe.padNext || (i == 0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldData <= '0;
      heldBase <= '0;
      nextBase <= '0;
      outSub   <= '0;
      outHash  <= '0;
      outPos   <= '0;
      outFull  <= '0;
    end else begin
      if (strobe.loadOut) begin
        outSub  <= subC;
        outHash <= hashC;
        outPos  <= posC;
        outFull <= fullC;
      end
      if (strobe.takeIn) begin
        heldData <= inData;
        heldBase <= nextBase;
        nextBase <= inLast ? '0 : nextBase + POS_W'(VEC);
      end
    end
  end

  // R7
  stall_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValidQ && !outReady |=> $stable(outSub) && $stable(outHash) && $stable(outPos) && $stable(outFull));
endmodule

// File: rtl/lz_hash_stage.sv
module lz_hash_stage
  import lzh_pkg::*;
#(
  parameter int VEC    = 16,
  parameter int HASH_W = 12,
  parameter int POS_W  = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  output logic                  inReady,
  input  logic [VEC*8-1:0]      inData,
  input  logic                  inLast,
  output logic                  outValid,
  input  logic                  outReady,
  output logic [VEC*VEC*8-1:0]  outSub,
  output logic [VEC*HASH_W-1:0] outHash,
  output logic [VEC*POS_W-1:0]  outPos,
  output logic [VEC-1:0]        outFull
);
  lzhStrobe_t strobe;

  lzh_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast),
    .inReady(inReady), .outValid(outValid), .outReady(outReady), .strobe(strobe)
  );

  lzh_datapath #(.VEC(VEC), .HASH_W(HASH_W), .POS_W(POS_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(inData), .inLast(inLast),
    .outValidQ(outValid), .outReady(outReady), .outSub(outSub),
    .outHash(outHash), .outPos(outPos), .outFull(outFull)
  );
endmodule

// File: tb/test_lz_hash_stage.sv
module test_lz_hash_stage;
  localparam int TV = 4;
  localparam int TH = 12;
  localparam int TP = 32;

  typedef struct {
    logic [TV*8-1:0] cur;
    logic [TV*8-1:0] nxt;
    int              base;
    bit              fin;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic [TV*8-1:0] inData = '0;
  logic inLast = 1'b0;
  logic outValid;
  logic outReady = 1'b1;
  logic [TV*TV*8-1:0] outSub;
  logic [TV*TH-1:0]   outHash;
  logic [TV*TP-1:0]   outPos;
  logic [TV-1:0]      outFull;

  int checks = 0;
  int errors = 0;
  int pushed = 0;
  int popped = 0;
  int cyc = 0;
  bit stallOn = 1'b0;
  bit done = 1'b0;
  item_t expQ[$];

  lz_hash_stage #(.VEC(TV), .HASH_W(TH), .POS_W(TP)) i_lz_hash_stage (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inData(inData),
    .inLast(inLast), .outValid(outValid), .outReady(outReady), .outSub(outSub),
    .outHash(outHash), .outPos(outPos), .outFull(outFull)
  );

  always #2.5 clk = ~clk;

  function automatic logic [TH-1:0] refHash(input logic [TV*8-1:0] s);
    logic [2*TH-1:0] x = '0;
    for (int j = 0; j < TV; j++) x = x ^ ((2*TH)'(16'(s[8*j +: 8]) * 16'd157) << (j % 8));
    return x[TH-1:0] ^ x[2*TH-1:TH];
  endfunction

  task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // outReady pattern
  always @(negedge clk) begin
    cyc <= cyc + 1;
    outReady <= !(stallOn && ((cyc % 5 == 2) || (cyc % 7 == 3)));
  end

  // driver: offers a window, pushes expected items
  logic [TV*8-1:0] prevWin;
  int  prevBase = 0;
  int  nextBase = 0;
  bit  havePrev = 0;

  task automatic sendWin(input logic [TV*8-1:0] w, input bit last);
    item_t it;
    @(negedge clk);
    inValid = 1'b1; inData = w; inLast = last;
    forever begin
      #1;
      if (inReady) break;
      @(negedge clk);
    end
    @(negedge clk);
    inValid = 1'b0;
    if (havePrev) begin
      it.cur = prevWin; it.nxt = w; it.base = prevBase; it.fin = 0;
      expQ.push_back(it); pushed++;
    end
    if (last) begin
      it.cur = w; it.nxt = '0; it.base = nextBase; it.fin = 1;
      expQ.push_back(it); pushed++;
      havePrev = 0; nextBase = 0;
    end else begin
      prevWin = w; prevBase = nextBase; havePrev = 1; nextBase += TV;
    end
  endtask

  // monitor
  logic [TV*TV*8-1:0] lastSub;
  logic [TV*TH-1:0]   lastHash;
  logic [TV*TP-1:0]   lastPos;
  bit prevStalled = 0;
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rstN) begin
        if (prevStalled) begin
          // R7: outputs held across a stall
          check(outValid && outSub == lastSub && outHash == lastHash && outPos == lastPos,
                "R7", "stall hold", outPos[TP-1:0], lastPos[TP-1:0]);
        end
        prevStalled = outValid && !outReady;
        lastSub = outSub; lastHash = outHash; lastPos = outPos;
        if (outValid && outReady) begin
          if (expQ.size() == 0) begin
            check(0, "R8", "unexpected output", 1, 0);
          end else begin
            item_t it;
            logic [2*TV*8-1:0] c;
            bit okS = 1, okH = 1, okP = 1, okF = 1;
            it = expQ.pop_front(); popped++;
            c = {it.nxt, it.cur};
            for (int i = 0; i < TV; i++) begin
              logic [TV*8-1:0] es;
              for (int j = 0; j < TV; j++) es[8*j +: 8] = c[8*(i+j) +: 8];
              if (outSub[i*TV*8 +: TV*8] != es) okS = 0;
              if (outHash[i*TH +: TH] != refHash(es)) okH = 0;
              if (outPos[i*TP +: TP] != TP'(it.base + i)) okP = 0;
              if (outFull[i] != (!it.fin || i == 0)) okF = 0;
            end
            check(okS, "R2", "substrings", outSub, c);
            check(okH, "R3", "hashes", outHash, refHash(outSub[TV*8-1:0]));
            check(okP, "R4", "positions", outPos[TP-1:0], it.base);
            check(okF, "R6", "full flags", outFull, it.fin ? 1 : 15);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1
    check(outValid == 1'b0, "R1", "outValid after reset", outValid, 0);
    check(inReady == 1'b1, "R1", "inReady after reset", inReady, 1);
    rstN = 1'b1;
    // R2 example: ABAA then ABCD
    sendWin({8'h41, 8'h41, 8'h42, 8'h41}, 0);
    repeat (4) @(negedge clk);
    #1;
    // R5: single window held, nothing emitted
    check(outValid == 1'b0, "R5", "no output before successor", outValid, 0);
    sendWin({8'h44, 8'h43, 8'h42, 8'h41}, 0);
    stallOn = 1'b1;
    for (int k = 0; k < 40; k++) sendWin(32'h9e3779b9 * (k + 3) ^ (k << 9), k == 39);
    // R4/R6: one-window stream right after a last window
    sendWin(32'hdeadbeef, 1);
    for (int k = 0; k < 25; k++) sendWin({8'(k), 8'(k * 7), 8'hff, 8'(k * 13)}, k == 24);
    for (int k = 0; k < 300 && expQ.size() != 0; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    // R8
    check(expQ.size() == 0, "R8", "pending windows", expQ.size(), 0);
    check(popped == pushed, "R8", "emitted count", popped, pushed);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule